// File: doc/BRIEF.md
# Two-Bank DRAM Strobe and Address Multiplexer

This block drives a pair of DRAM banks built from 256Kx1 devices, each bank holding 512K bytes. Its outputs are a 9-bit multiplexed address bus, active-low row strobes (one per bank), active-low column strobes (one per byte lane) and an active-low flag that marks a DMA cycle in progress. Three requesters share the memory: the processor, a DMA engine and a refresh source.

Each memory cycle is run by a fixed sequencer. A cycle has a row phase, a column phase, a column-strobe phase and a one-clock precharge. The row address goes out while the row strobe falls. The column address follows one clock later, and the column strobes fall one clock after that. The winning requester gets a one-clock acknowledge in the column-strobe phase. A requester holds its request as a level and withdraws it after the acknowledge.

An 18-bit word address is split into a 9-bit row (bits 17..9) and a 9-bit column (bits 8..0). For the processor, the word address is byte-address bits A18..A1 and A19 selects the bank. DMA reaches only the lower bank. A refresh cycle strobes the given row into both banks and asserts no column strobe.

Top module: `dram_strobe_mux`

## Requirements
- R1: While reset is high, and in the first cycle after it, all four strobes and the DMA flag are high (deasserted), the bus enable is low and all acknowledges are low.
- R2: A cycle presents the row (word bits 17..9) on the bus in the clock after arbitration, with its row strobe low. The column (word bits 8..0) follows in the next clock. The column strobes fall one clock after that.
- R3: A processor cycle (RAM enable low) asserts the lower-bank row strobe when A19 is 0 and the upper-bank row strobe when A19 is 1, never both.
- R4: In a processor cycle, the low-byte column strobe is asserted only if the lower data strobe was low, and the high-byte column strobe only if the upper data strobe was low. With both data strobes high, neither column strobe falls.
- R5: A DMA cycle asserts the DMA flag, the lower-bank row strobe and both column strobes. It never asserts the upper-bank row strobe. Its address is the 18-bit DMA word address.
- R6: A refresh cycle asserts both row strobes and the DMA flag, asserts no column strobe, and shows the refresh row on the bus in both address phases.
- R7: The bus enable is high only during the row, column and column-strobe phases. While it is low, the bus reads zero and no strobe is asserted.
- R8: When several requests are present at arbitration, refresh wins over DMA and DMA wins over the processor.
- R9: A cycle that has started runs all its phases with the same owner and address, even if a higher-priority request arrives.
- R10: Every cycle ends with exactly one clock in which all strobes are high, including between back-to-back cycles.
- R11: Exactly one acknowledge (processor, DMA or refresh, matching the owner) pulses for one clock, in the column-strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 19 | Processor byte address bits A19..A1 |
| cpu_ram_en_n | input | 1 | Processor RAM enable, active low (request) |
| cpu_lds_n | input | 1 | Processor lower data strobe, active low |
| cpu_uds_n | input | 1 | Processor upper data strobe, active low |
| dma_req | input | 1 | DMA transfer request |
| dma_addr | input | 18 | DMA word address (lower bank) |
| ref_req | input | 1 | Refresh request |
| ref_row | input | 9 | Row to refresh |
| ma | output | 9 | Multiplexed DRAM address |
| ma_oe | output | 1 | Address bus drive enable |
| ras0_n | output | 1 | Lower-bank row strobe, active low |
| ras1_n | output | 1 | Upper-bank row strobe, active low |
| casl_n | output | 1 | Low-byte column strobe, active low |
| casu_n | output | 1 | High-byte column strobe, active low |
| dma_act_n | output | 1 | DMA/refresh cycle underway, active low |
| cpu_ack | output | 1 | Processor acknowledge pulse |
| dma_ack | output | 1 | DMA acknowledge pulse |
| ref_ack | output | 1 | Refresh acknowledge pulse |

## Verification
The hardest case to produce is a higher-priority request that arrives after a processor cycle has already begun. The stimulus raises the refresh request in the row phase of a processor cycle. It then checks that the column phase, byte strobes and acknowledge still belong to the processor, and that the refresh cycle follows only after one precharge clock. A second hard case is a three-way collision: all requests are raised on the same clock, and each one is withdrawn only when acknowledged. This shows the refresh, DMA and processor cycles running back to back in priority order.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    localparam int ROW_W  = 9;
    localparam int WORD_W = 2 * ROW_W;
    localparam int BANK_BIT = WORD_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_PRE
    } seq_state_t;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_CPU,
        OWN_DMA,
        OWN_REF
    } owner_t;

    typedef struct packed {
        owner_t             owner;
        logic               bank_hi;
        logic               lo_en;
        logic               hi_en;
        logic [ROW_W-1:0]   row;
        logic [ROW_W-1:0]   col;
    } cycle_t;

    function automatic logic [ROW_W-1:0] row_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:ROW_W];
    endfunction

    function automatic logic [ROW_W-1:0] col_of(input logic [WORD_W-1:0] w);
        return w[ROW_W-1:0];
    endfunction

endpackage

// File: rtl/dram_arbiter.sv
module dram_arbiter
    import dram_mux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BANK_BIT:1]     cpu_addr,
    input  logic                  cpu_ram_en_n,
    input  logic                  cpu_lds_n,
    input  logic                  cpu_uds_n,
    input  logic                  dma_req,
    input  logic [WORD_W-1:0]     dma_addr,
    input  logic                  ref_req,
    input  logic [ROW_W-1:0]      ref_row,
    output cycle_t                next_cyc
);

    logic [WORD_W-1:0] cpu_word;
    assign cpu_word = cpu_addr[WORD_W:1];

    always_comb begin
        next_cyc = '0;
        if (ref_req) begin
            next_cyc.owner = OWN_REF;
            next_cyc.row   = ref_row;
            next_cyc.col   = ref_row;
        end else if (dma_req) begin
            next_cyc.owner = OWN_DMA;
            next_cyc.lo_en = 1'b1;
            next_cyc.hi_en = 1'b1;
            next_cyc.row   = row_of(dma_addr);
            next_cyc.col   = col_of(dma_addr);
        end else if (!cpu_ram_en_n) begin
            next_cyc.owner   = OWN_CPU;
            next_cyc.bank_hi = cpu_addr[BANK_BIT];
            next_cyc.lo_en   = !cpu_lds_n;
            next_cyc.hi_en   = !cpu_uds_n;
            next_cyc.row     = row_of(cpu_word);
            next_cyc.col     = col_of(cpu_word);
        end
    end

    // R8
    ref_first_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> next_cyc.owner == OWN_REF);

    // R8
    dma_over_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_req && dma_req) |-> next_cyc.owner == OWN_DMA);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cycle_t      next_cyc,
    output seq_state_t  state,
    output cycle_t      cur_cyc
);

    logic can_start;
    assign can_start = (state == ST_IDLE) || (state == ST_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_cyc <= '0;
        end else begin
            unique case (state)
                ST_ROW:  state <= ST_COL;
                ST_COL:  state <= ST_CAS;
                ST_CAS:  state <= ST_PRE;
                default: begin
                    if (next_cyc.owner != OWN_NONE) begin
                        state   <= ST_ROW;
                        cur_cyc <= next_cyc;
                    end else begin
                        state   <= ST_IDLE;
                        cur_cyc <= '0;
                    end
                end
            endcase
        end
    end

    // R9
    hold_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROW || state == ST_COL) |=> $stable(cur_cyc));

    // R10
    cas_to_pre_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_CAS |=> state == ST_PRE);

    // R2
    row_to_col_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_ROW |=> state == ST_COL);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (can_start && next_cyc.owner != OWN_NONE) |=> state == ST_ROW);

endmodule

// File: rtl/dram_strobe_dec.sv
module dram_strobe_dec
    import dram_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  cycle_t            cur_cyc,
    output logic [ROW_W-1:0]  ma,
    output logic              ma_oe,
    output logic              ras0_n,
    output logic              ras1_n,
    output logic              casl_n,
    output logic              casu_n,
    output logic              dma_act_n,
    output logic              cpu_ack,
    output logic              dma_ack,
    output logic              ref_ack
);

    logic active, cas_ph, is_cpu, is_dma, is_ref;

    assign active = (state == ST_ROW) || (state == ST_COL) || (state == ST_CAS);
    assign cas_ph = (state == ST_CAS);
    assign is_cpu = (cur_cyc.owner == OWN_CPU);
    assign is_dma = (cur_cyc.owner == OWN_DMA);
    assign is_ref = (cur_cyc.owner == OWN_REF);

    always_comb begin
        ma_oe     = active;
        ma        = '0;
        if (state == ST_ROW)
            ma = cur_cyc.row;
        else if (active)
            ma = cur_cyc.col;
        ras0_n    = !(active && (is_ref || is_dma || (is_cpu && !cur_cyc.bank_hi)));
        ras1_n    = !(active && (is_ref || (is_cpu && cur_cyc.bank_hi)));
        casl_n    = !(cas_ph && (is_dma || is_cpu) && cur_cyc.lo_en);
        casu_n    = !(cas_ph && (is_dma || is_cpu) && cur_cyc.hi_en);
        dma_act_n = !(active && (is_dma || is_ref));
        cpu_ack   = cas_ph && is_cpu;
        dma_ack   = cas_ph && is_dma;
        ref_ack   = cas_ph && is_ref;
    end

    // R6
    refresh_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras1_n && !dma_act_n) |-> (!ras0_n && casl_n && casu_n));

    // R5
    dma_low_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (!dma_act_n && ras1_n) |-> !ras0_n);

    // R11
    one_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_ack, dma_ack, ref_ack}));

    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !ma_oe |-> (ma == '0 && ras0_n && ras1_n && casl_n && casu_n && dma_act_n));

    // R3
    one_bank_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        dma_act_n |-> (ras0_n || ras1_n));

endmodule

// File: rtl/dram_strobe_mux.sv
module dram_strobe_mux
    import dram_mux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BANK_BIT:1]    cpu_addr,
    input  logic                 cpu_ram_en_n,
    input  logic                 cpu_lds_n,
    input  logic                 cpu_uds_n,
    input  logic                 dma_req,
    input  logic [WORD_W-1:0]    dma_addr,
    input  logic                 ref_req,
    input  logic [ROW_W-1:0]     ref_row,
    output logic [ROW_W-1:0]     ma,
    output logic                 ma_oe,
    output logic                 ras0_n,
    output logic                 ras1_n,
    output logic                 casl_n,
    output logic                 casu_n,
    output logic                 dma_act_n,
    output logic                 cpu_ack,
    output logic                 dma_ack,
    output logic                 ref_ack
);

    cycle_t     next_cyc;
    cycle_t     cur_cyc;
    seq_state_t state;

    dram_arbiter u_arb (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .cpu_ram_en_n (cpu_ram_en_n),
        .cpu_lds_n    (cpu_lds_n),
        .cpu_uds_n    (cpu_uds_n),
        .dma_req      (dma_req),
        .dma_addr     (dma_addr),
        .ref_req      (ref_req),
        .ref_row      (ref_row),
        .next_cyc     (next_cyc)
    );

    dram_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .next_cyc (next_cyc),
        .state    (state),
        .cur_cyc  (cur_cyc)
    );

    dram_strobe_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .cur_cyc   (cur_cyc),
        .ma        (ma),
        .ma_oe     (ma_oe),
        .ras0_n    (ras0_n),
        .ras1_n    (ras1_n),
        .casl_n    (casl_n),
        .casu_n    (casu_n),
        .dma_act_n (dma_act_n),
        .cpu_ack   (cpu_ack),
        .dma_ack   (dma_ack),
        .ref_ack   (ref_ack)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (ras0_n && ras1_n && casl_n && casu_n && dma_act_n && !ma_oe
                 && !cpu_ack && !dma_ack && !ref_ack));

endmodule

// File: tb/dram_strobe_mux_test.sv
`timescale 1ns/1ps
module dram_strobe_mux_test;

    localparam logic [1:0] K_CPU = 2'd1, K_DMA = 2'd2, K_REF = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [18:0] addr;
        logic        lds_n;
        logic        uds_n;
        logic [4:0]  exp;   // {ras0_n, ras1_n, casl_n, casu_n, dma_act_n} in strobe phase
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{K_CPU, 19'h0_1234, 1'b0, 1'b0, 5'b01001},
        '{K_CPU, 19'h4_ABCD, 1'b0, 1'b1, 5'b10011},
        '{K_CPU, 19'h7_FFFF, 1'b1, 1'b0, 5'b10101},
        '{K_CPU, 19'h3_FFFF, 1'b1, 1'b1, 5'b01111},
        '{K_DMA, 19'h2_5A5A, 1'b1, 1'b1, 5'b01000},
        '{K_DMA, 19'h3_FFFF, 1'b1, 1'b1, 5'b01000},
        '{K_REF, 19'h0_01AB, 1'b1, 1'b1, 5'b00110}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:1] cpu_addr = '0;
    logic        cpu_ram_en_n = 1'b1, cpu_lds_n = 1'b1, cpu_uds_n = 1'b1;
    logic        dma_req = 1'b0, ref_req = 1'b0;
    logic [17:0] dma_addr = '0;
    logic [8:0]  ref_row = '0;
    logic [8:0]  ma;
    logic        ma_oe, ras0_n, ras1_n, casl_n, casu_n, dma_act_n;
    logic        cpu_ack, dma_ack, ref_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_strobe_mux uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_ram_en_n(cpu_ram_en_n),
        .cpu_lds_n(cpu_lds_n), .cpu_uds_n(cpu_uds_n), .dma_req(dma_req),
        .dma_addr(dma_addr), .ref_req(ref_req), .ref_row(ref_row),
        .ma(ma), .ma_oe(ma_oe), .ras0_n(ras0_n), .ras1_n(ras1_n),
        .casl_n(casl_n), .casu_n(casu_n), .dma_act_n(dma_act_n),
        .cpu_ack(cpu_ack), .dma_ack(dma_ack), .ref_ack(ref_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] exp_row(input logic [1:0] k, input logic [18:0] a);
        return (k == K_REF) ? a[8:0] : a[17:9];
    endfunction

    function automatic logic [8:0] exp_col(input logic [1:0] k, input logic [18:0] a);
        return a[8:0];
    endfunction

    function automatic logic [2:0] exp_ack(input logic [1:0] k);
        return (k == K_REF) ? 3'b100 : (k == K_DMA) ? 3'b010 : 3'b001;
    endfunction

    task automatic add_req(input logic [1:0] k, input logic [18:0] a, input logic l, input logic u);
        if (k == K_CPU) begin
            cpu_addr = a; cpu_ram_en_n = 1'b0; cpu_lds_n = l; cpu_uds_n = u;
        end else if (k == K_DMA) begin
            dma_req = 1'b1; dma_addr = a[17:0];
        end else begin
            ref_req = 1'b1; ref_row = a[8:0];
        end
    endtask

    task automatic drop_req(input logic [1:0] k);
        if (k == K_CPU) begin
            cpu_ram_en_n = 1'b1; cpu_lds_n = 1'b1; cpu_uds_n = 1'b1;
        end else if (k == K_DMA) dma_req = 1'b0;
        else ref_req = 1'b0;
    endtask

    // samples row, column and strobe phases of one cycle
    task automatic watch_act(input logic [1:0] k, input logic [18:0] a, input logic [4:0] e);
        @(negedge clk);
        chk("R2 row on bus", ma, exp_row(k, a));
        chk("R7 bus enable row", ma_oe, 1'b1);
        chk("R3 row strobes in row phase", {ras0_n, ras1_n}, e[4:3]);
        chk("R2 no CAS in row phase", {casl_n, casu_n}, 2'b11);
        @(negedge clk);
        chk("R2 column on bus", ma, exp_col(k, a));
        chk("R2 no CAS in column phase", {casl_n, casu_n}, 2'b11);
        @(negedge clk);
        chk("R4 R5 R6 strobe pattern", {ras0_n, ras1_n, casl_n, casu_n, dma_act_n}, e);
        chk("R11 acknowledge", {ref_ack, dma_ack, cpu_ack}, exp_ack(k));
    endtask

    task automatic watch_pre();
        @(negedge clk);
        chk("R10 precharge strobes high",
            {ras0_n, ras1_n, casl_n, casu_n, dma_act_n}, 5'b11111);
        chk("R7 bus released", {ma_oe, ma}, 10'd0);
        chk("R11 no ack in precharge", {ref_ack, dma_ack, cpu_ack}, 3'b000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with a request pending
        ref_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 quiet during reset", {ras0_n, ras1_n, casl_n, casu_n, dma_act_n, ma_oe}, 6'b111110);
        ref_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 quiet after reset",
            {ras0_n, ras1_n, casl_n, casu_n, dma_act_n, ma_oe, ref_ack, dma_ack, cpu_ack},
            9'b111110000);

        // table walk: R2 R3 R4 R5 R6 R7 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            add_req(VEC[i].kind, VEC[i].addr, VEC[i].lds_n, VEC[i].uds_n);
            watch_act(VEC[i].kind, VEC[i].addr, VEC[i].exp);
            drop_req(VEC[i].kind);
            watch_pre();
        end

        // R9: refresh arrives in the row phase of a processor cycle
        @(negedge clk);
        add_req(K_CPU, 19'h4_0155, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 processor cycle began", {ras0_n, ras1_n}, 2'b10);
        add_req(K_REF, 19'h0_0077, 1'b1, 1'b1);
        @(negedge clk);
        chk("R9 column stays processor", ma, 9'h155);
        chk("R9 upper bank kept", {ras0_n, ras1_n, dma_act_n}, 3'b101);
        @(negedge clk);
        chk("R9 processor strobes finish",
            {ras0_n, ras1_n, casl_n, casu_n, dma_act_n, cpu_ack, ref_ack}, 7'b1001110);
        drop_req(K_CPU);
        watch_pre();
        watch_act(K_REF, 19'h0_0077, 5'b00110);
        drop_req(K_REF);
        watch_pre();

        // R8: all three requests at once
        @(negedge clk);
        add_req(K_CPU, 19'h0_2468, 1'b0, 1'b0);
        add_req(K_DMA, 19'h1_1357, 1'b1, 1'b1);
        add_req(K_REF, 19'h0_0100, 1'b1, 1'b1);
        watch_act(K_REF, 19'h0_0100, 5'b00110);
        chk("R8 refresh won first", ref_ack, 1'b1);
        drop_req(K_REF);
        watch_pre();
        watch_act(K_DMA, 19'h1_1357, 5'b01000);
        chk("R8 DMA won second", dma_ack, 1'b1);
        drop_req(K_DMA);
        watch_pre();
        watch_act(K_CPU, 19'h0_2468, 5'b01001);
        chk("R8 processor served last", cpu_ack, 1'b1);
        drop_req(K_CPU);
        watch_pre();
        @(negedge clk);
        chk("R7 idle after queue drains", {ma_oe, ras0_n, ras1_n}, 3'b011);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule